// File: doc/BRIEF.md
# Per-Line Branch Prediction Sequencer

This block sits behind instruction fetch. It takes one aligned fetch line of four instruction slots together with a mask that marks which slots hold branches, the line's base address and a target address for each slot. It then predicts the branches of that line one at a time, in program order, with at most one prediction per cycle. The walk ends when a branch is predicted taken or when the last marked branch has been predicted not taken. At that point the block reports the address to fetch next and how many slots of the line are on the predicted path.

Direction comes from a table of 2-bit saturating counters. The table is indexed by the word address bits of the branch XORed with a global history register. Every prediction shifts its predicted direction into that history. Branch resolution trains the counter that the branch used. On a misprediction the history is reloaded from a checkpoint that comes with the resolve. The fetch side keeps the history value shown beside each prediction and returns it later as the resolve index and the checkpoint.

Top module: `line_branch_stepper`

## Requirements
- R1: While reset is high (active-high, synchronous), history is cleared, every counter is set to weakly not-taken (value 1), and the sequencer goes idle. After reset, done_o=1, pred_valid_o=0, line_done_o=0 and pred_hist_o=0.
- R2: In each cycle the sequencer predicts at most one branch of the current line (pred_valid_o=1). Successive predictions of one line go in strictly rising slot order. Slot 0 is the lowest address, and slot s sits at line address + 4*s.
- R3: When a branch in slot s is predicted taken, line_done_o=1 in that same cycle, nvalid_o=s+1, next_addr_o is the target for slot s (bits [32*s+31:32*s] of line_tgt_i), and no further slot of the line is predicted.
- R4: If every marked branch of a line is predicted not taken, the cycle that predicts the last one has line_done_o=1, nvalid_o=4 and next_addr_o = line address + 16.
- R5: A line with an all-zero branch mask completes in the cycle after it is accepted: no prediction is made, line_done_o=1, nvalid_o=4 and next_addr_o = line address + 16.
- R6: The direction of the branch at address pc is read from counter (pc[9:2] XOR history[7:0]). It is taken when the counter is 2 or 3.
- R7: Each prediction shifts the history left by one bit and puts the predicted direction (1 = taken) into bit 0. With no prediction and no mismatch, the history holds.
- R8: A resolve (resolve_valid_i=1) steps the counter at (resolve_pc_i[9:2] XOR resolve_hist_i) up by one if resolve_taken_i=1, or down by one otherwise. The counter saturates at 3 and at 0.
- R9: A resolve with resolve_mispredict_i=1 loads resolve_ckpt_i into the history on the next edge. This takes priority over a prediction made in the same cycle.
- R10: A new line is taken only in a cycle where done_o=1. line_valid_i has no effect while done_o=0, and the line in progress continues unchanged.
- R11: done_o is 1 when idle and in the cycle that makes the final prediction of a line. A line offered in that cycle is accepted there, and its first prediction comes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_valid_i | input | 1 | A fetch line is offered |
| line_addr_i | input | 32 | Base address of the line (16-byte aligned) |
| line_brmask_i | input | 4 | One bit per slot, set where the slot holds a branch |
| line_tgt_i | input | 128 | Per-slot target addresses, slot s in bits [32*s+31:32*s] |
| done_o | output | 1 | Ready for a new line this cycle |
| pred_valid_o | output | 1 | A branch is predicted this cycle |
| pred_slot_o | output | 2 | Slot of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction |
| pred_hist_o | output | 8 | History used for this cycle's lookup |
| line_done_o | output | 1 | Final result of the line is on the outputs |
| next_addr_o | output | 32 | Next fetch address for the finished line |
| nvalid_o | output | 3 | Number of slots on the predicted path |
| resolve_valid_i | input | 1 | A branch outcome is reported |
| resolve_pc_i | input | 32 | Address of the resolved branch |
| resolve_hist_i | input | 8 | History the resolved branch was predicted with |
| resolve_taken_i | input | 1 | Actual direction |
| resolve_mispredict_i | input | 1 | Prediction was wrong: restore history |
| resolve_ckpt_i | input | 8 | History value to restore |

## Verification
The bench goes after lines whose first marked branch is taken, lines whose branches are all not taken, and lines with no branches at all. A design that kept stepping after a taken branch, or that counted valid slots from the wrong end, would show a wrong slot count or next address. It also offers a new line while a walk is still running, and checks that the offer neither cuts the walk short nor overwrites its address. It trains one counter past its ceiling and then back by one, which catches a counter that wraps instead of saturating. It also raises a mismatch in the same cycle as a prediction, where a design that let the speculative shift win would show the wrong history on the next cycle.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

   // Sequencer phase: idle, or walking the branches of one line
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_WALK = 1'b1
   } seq_state_e;

endpackage

// File: rtl/lbp_index_hash.sv
module lbp_index_hash #(
   parameter int IDX_W     = 8,
   parameter bit HASH_HIST = 1'b1
) (
   input  logic [IDX_W-1:0] pc_bits,
   input  logic [IDX_W-1:0] hist,
   output logic [IDX_W-1:0] idx
);

   generate
      if (HASH_HIST) begin : g_xor
         // history folded into the address bits
         assign idx = pc_bits ^ hist;
      end else begin : g_addr_only
         // address-only indexing
         logic unused_hist;
         assign unused_hist = ^hist;
         assign idx = pc_bits;
      end
   endgenerate

endmodule

// File: rtl/lbp_dir_table.sv
module lbp_dir_table #(
   parameter int IDX_W = 8,
   parameter int CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);

   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = '1;
   localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

   logic [CTR_W-1:0] mem_q [DEPTH];
   logic [CTR_W-1:0] cur;

   assign rd_ctr = mem_q[rd_idx];
   assign cur    = mem_q[wr_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= WEAK_NT;
         end
      end else if (wr_en) begin
         if (wr_up && (cur != CTR_MAX)) begin
            mem_q[wr_idx] <= cur + 1'b1;
         end else if (!wr_up && (cur != '0)) begin
            mem_q[wr_idx] <= cur - 1'b1;
         end
      end
   end

endmodule

// File: rtl/lbp_ghist.sv
module lbp_ghist #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              shift_bit,
   input  logic              restore_en,
   input  logic [HIST_W-1:0] restore_val,
   output logic [HIST_W-1:0] hist
);

   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= '0;
      end else if (restore_en) begin
         hist_q <= restore_val;
      end else if (shift_en) begin
         hist_q <= {hist_q[HIST_W-2:0], shift_bit};
      end
   end

   assign hist = hist_q;

endmodule

// File: rtl/lbp_slot_pick.sv
module lbp_slot_pick #(
   parameter int SLOTS = 4
) (
   input  logic [SLOTS-1:0]         rem,
   output logic                     any,
   output logic [$clog2(SLOTS)-1:0] first,
   output logic [SLOTS-1:0]         rest,
   output logic                     more
);

   localparam int SLOT_W = $clog2(SLOTS);

   always_comb begin
      any   = |rem;
      first = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (rem[s]) begin
            first = SLOT_W'(s);
         end
      end
      rest = rem & ~(SLOTS'(1) << first);
      more = |rest;
   end

endmodule

// File: rtl/line_branch_stepper.sv
module line_branch_stepper
   import lbp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SLOTS      = 4,
   parameter int INST_BYTES = 4,
   parameter int HIST_W     = 8,
   parameter int CTR_W      = 2,
   parameter bit HASH_HIST  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         line_valid_i,
   input  logic [ADDR_W-1:0]            line_addr_i,
   input  logic [SLOTS-1:0]             line_brmask_i,
   input  logic [SLOTS*ADDR_W-1:0]      line_tgt_i,
   output logic                         done_o,
   output logic                         pred_valid_o,
   output logic [$clog2(SLOTS)-1:0]     pred_slot_o,
   output logic                         pred_taken_o,
   output logic [HIST_W-1:0]            pred_hist_o,
   output logic                         line_done_o,
   output logic [ADDR_W-1:0]            next_addr_o,
   output logic [$clog2(SLOTS+1)-1:0]   nvalid_o,
   input  logic                         resolve_valid_i,
   input  logic [ADDR_W-1:0]            resolve_pc_i,
   input  logic [HIST_W-1:0]            resolve_hist_i,
   input  logic                         resolve_taken_i,
   input  logic                         resolve_mispredict_i,
   input  logic [HIST_W-1:0]            resolve_ckpt_i
);

   localparam int SLOT_W = $clog2(SLOTS);
   localparam int CNT_W  = $clog2(SLOTS + 1);
   localparam int OFF    = $clog2(INST_BYTES);
   localparam int IDX_W  = HIST_W;
   localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(SLOTS * INST_BYTES);

   // parameter legality
   initial begin : p_param_check
      if ((SLOTS < 2) || ((SLOTS & (SLOTS - 1)) != 0))
         $fatal(1, "SLOTS must be a power of two, at least 2");
      if ((INST_BYTES < 2) || ((INST_BYTES & (INST_BYTES - 1)) != 0))
         $fatal(1, "INST_BYTES must be a power of two, at least 2");
      if ((HIST_W < 2) || (HIST_W > 12))
         $fatal(1, "HIST_W must lie in 2..12");
      if ((CTR_W < 2) || (CTR_W > 4))
         $fatal(1, "CTR_W must lie in 2..4");
      if (ADDR_W <= (IDX_W + OFF))
         $fatal(1, "ADDR_W too narrow for the table index");
   end

   // ---------------- line state ----------------
   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SLOTS-1:0]  rem_q;
   logic [ADDR_W-1:0] tgt_q [SLOTS];
   logic [ADDR_W-1:0] tgt_in [SLOTS];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_tgt_unpack
         assign tgt_in[s] = line_tgt_i[s*ADDR_W +: ADDR_W];
      end
   endgenerate

   // ---------------- slot selection ----------------
   logic              any_br;
   logic [SLOT_W-1:0] cur_slot;
   logic [SLOTS-1:0]  rem_next;
   logic              more_br;

   lbp_slot_pick #(.SLOTS(SLOTS)) i_pick (
      .rem   (rem_q),
      .any   (any_br),
      .first (cur_slot),
      .rest  (rem_next),
      .more  (more_br)
   );

   // ---------------- direction lookup ----------------
   logic [HIST_W-1:0] hist;
   logic [IDX_W-1:0]  lk_pc_bits;
   logic [IDX_W-1:0]  lk_idx;
   logic [IDX_W-1:0]  tr_idx;
   logic [CTR_W-1:0]  lk_ctr;
   logic              lk_taken;

   // word address bits of the slot: line base plus slot number
   assign lk_pc_bits = addr_q[OFF +: IDX_W] + IDX_W'(cur_slot);

   lbp_index_hash #(.IDX_W(IDX_W), .HASH_HIST(HASH_HIST)) i_lk_hash (
      .pc_bits (lk_pc_bits),
      .hist    (hist),
      .idx     (lk_idx)
   );

   lbp_index_hash #(.IDX_W(IDX_W), .HASH_HIST(HASH_HIST)) i_tr_hash (
      .pc_bits (resolve_pc_i[OFF +: IDX_W]),
      .hist    (resolve_hist_i),
      .idx     (tr_idx)
   );

   lbp_dir_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) i_table (
      .clk    (clk),
      .rst    (rst),
      .rd_idx (lk_idx),
      .rd_ctr (lk_ctr),
      .wr_en  (resolve_valid_i),
      .wr_idx (tr_idx),
      .wr_up  (resolve_taken_i)
   );

   assign lk_taken = lk_ctr[CTR_W-1];

   // ---------------- step control ----------------
   logic walking;
   logic final_step;
   logic accept;
   logic restore;

   assign walking    = (state_q == SEQ_WALK);
   assign final_step = !any_br || lk_taken || !more_br;
   assign restore    = resolve_valid_i && resolve_mispredict_i;

   assign pred_valid_o = walking && any_br;
   assign pred_taken_o = pred_valid_o && lk_taken;
   assign pred_slot_o  = cur_slot;
   assign pred_hist_o  = hist;
   assign done_o       = !walking || final_step;
   assign line_done_o  = walking && final_step;
   assign accept       = line_valid_i && done_o;

   assign next_addr_o = pred_taken_o ? tgt_q[cur_slot] : (addr_q + LINE_BYTES);
   assign nvalid_o    = pred_taken_o ? (CNT_W'(cur_slot) + CNT_W'(1)) : CNT_W'(SLOTS);

   lbp_ghist #(.HIST_W(HIST_W)) i_hist (
      .clk         (clk),
      .rst         (rst),
      .shift_en    (pred_valid_o),
      .shift_bit   (lk_taken),
      .restore_en  (restore),
      .restore_val (resolve_ckpt_i),
      .hist        (hist)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         for (int s = 0; s < SLOTS; s++) begin
            tgt_q[s] <= '0;
         end
      end else if (accept) begin
         state_q <= SEQ_WALK;
         addr_q  <= line_addr_i;
         rem_q   <= line_brmask_i;
         for (int s = 0; s < SLOTS; s++) begin
            tgt_q[s] <= tgt_in[s];
         end
      end else if (line_done_o) begin
         state_q <= SEQ_IDLE;
      end else if (pred_valid_o) begin
         rem_q <= rem_next;
      end
   end

   // bits not needed by the index or the direction decision
   logic unused_bits;
   assign unused_bits = ^{resolve_pc_i[ADDR_W-1:OFF+IDX_W], resolve_pc_i[OFF-1:0],
                          lk_ctr[CTR_W-2:0]};

endmodule

// File: rtl/line_branch_stepper_chk.sv
module line_branch_stepper_chk #(
   parameter int SLOTS  = 4,
   parameter int HIST_W = 8
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       done_o,
   input logic                       pred_valid_o,
   input logic [$clog2(SLOTS)-1:0]   pred_slot_o,
   input logic                       pred_taken_o,
   input logic [HIST_W-1:0]          pred_hist_o,
   input logic                       line_done_o,
   input logic [$clog2(SLOTS+1)-1:0] nvalid_o,
   input logic                       resolve_valid_i,
   input logic                       resolve_mispredict_i,
   input logic [HIST_W-1:0]          resolve_ckpt_i
);

   localparam int CNT_W = $clog2(SLOTS + 1);

   logic mism;
   assign mism = resolve_valid_i && resolve_mispredict_i;

   // R1: state right after a reset cycle
   a_r1_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (pred_hist_o == '0 && done_o && !line_done_o && !pred_valid_o));

   // R2: a walk that is not finished predicts a later slot next cycle
   a_r2_rising_slots: assert property (@(posedge clk) disable iff (rst)
      (pred_valid_o && !line_done_o) |=> (pred_valid_o && (pred_slot_o > $past(pred_slot_o))));

   // R3: a taken prediction ends the line with slot+1 valid slots
   a_r3_taken_ends: assert property (@(posedge clk) disable iff (rst)
      pred_taken_o |-> (line_done_o && done_o && nvalid_o == (CNT_W'(pred_slot_o) + CNT_W'(1))));

   // R4: a line finished without a taken branch keeps all slots
   a_r4_full_line: assert property (@(posedge clk) disable iff (rst)
      (line_done_o && !pred_taken_o) |-> (nvalid_o == CNT_W'(SLOTS)));

   // R7: history shift on a prediction
   a_r7_hist_shift: assert property (@(posedge clk) disable iff (rst)
      (pred_valid_o && !mism) |=>
         (pred_hist_o == {$past(pred_hist_o[HIST_W-2:0]), $past(pred_taken_o)}));

   // R7: history holds without prediction or mismatch
   a_r7_hist_hold: assert property (@(posedge clk) disable iff (rst)
      (!pred_valid_o && !mism) |=> $stable(pred_hist_o));

   // R9: mismatch restores the checkpoint
   a_r9_restore: assert property (@(posedge clk) disable iff (rst)
      mism |=> (pred_hist_o == $past(resolve_ckpt_i)));

   // R11: the final cycle of a line is also a ready cycle
   a_r11_done_on_final: assert property (@(posedge clk) disable iff (rst)
      line_done_o |-> done_o);

endmodule

bind line_branch_stepper line_branch_stepper_chk #(
   .SLOTS  (SLOTS),
   .HIST_W (HIST_W)
) i_chk (
   .clk                  (clk),
   .rst                  (rst),
   .done_o               (done_o),
   .pred_valid_o         (pred_valid_o),
   .pred_slot_o          (pred_slot_o),
   .pred_taken_o         (pred_taken_o),
   .pred_hist_o          (pred_hist_o),
   .line_done_o          (line_done_o),
   .nvalid_o             (nvalid_o),
   .resolve_valid_i      (resolve_valid_i),
   .resolve_mispredict_i (resolve_mispredict_i),
   .resolve_ckpt_i       (resolve_ckpt_i)
);

// File: tb/test_line_branch_stepper.sv
module test_line_branch_stepper;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         line_valid_i = 1'b0;
   logic [31:0]  line_addr_i = '0;
   logic [3:0]   line_brmask_i = '0;
   logic [127:0] line_tgt_i = '0;
   logic         done_o;
   logic         pred_valid_o;
   logic [1:0]   pred_slot_o;
   logic         pred_taken_o;
   logic [7:0]   pred_hist_o;
   logic         line_done_o;
   logic [31:0]  next_addr_o;
   logic [2:0]   nvalid_o;
   logic         resolve_valid_i = 1'b0;
   logic [31:0]  resolve_pc_i = '0;
   logic [7:0]   resolve_hist_i = '0;
   logic         resolve_taken_i = 1'b0;
   logic         resolve_mispredict_i = 1'b0;
   logic [7:0]   resolve_ckpt_i = '0;

   always #2 clk = ~clk;   // 250 MHz

   line_branch_stepper i_line_branch_stepper (
      .clk(clk), .rst(rst),
      .line_valid_i(line_valid_i), .line_addr_i(line_addr_i),
      .line_brmask_i(line_brmask_i), .line_tgt_i(line_tgt_i),
      .done_o(done_o), .pred_valid_o(pred_valid_o), .pred_slot_o(pred_slot_o),
      .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
      .line_done_o(line_done_o), .next_addr_o(next_addr_o), .nvalid_o(nvalid_o),
      .resolve_valid_i(resolve_valid_i), .resolve_pc_i(resolve_pc_i),
      .resolve_hist_i(resolve_hist_i), .resolve_taken_i(resolve_taken_i),
      .resolve_mispredict_i(resolve_mispredict_i), .resolve_ckpt_i(resolve_ckpt_i)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // reference model state
   int unsigned m_ctr [256];
   logic [7:0]  m_hist;
   bit          m_active;
   logic [31:0] m_addr;
   logic [3:0]  m_rem;
   logic [31:0] m_tgt [4];
   bit          prev_ignored;

   function automatic int first_of(logic [3:0] r);
      int f = 0;
      for (int s = 3; s >= 0; s--) if (r[s]) f = s;
      return f;
   endfunction

   function automatic logic [7:0] idx_of(logic [31:0] pc, logic [7:0] h);
      return pc[9:2] ^ h;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_ctr[i] = 1;
      m_hist = '0; m_active = 1'b0; m_addr = '0; m_rem = '0; prev_ignored = 1'b0;
      for (int s = 0; s < 4; s++) m_tgt[s] = '0;
   endtask

   // one cycle: check state visible now, drive inputs for the coming edge, advance model
   task automatic step(input bit lv, input logic [31:0] la, input logic [3:0] lm,
                       input logic [127:0] lt, input bit rv, input logic [31:0] rpc,
                       input logic [7:0] rh, input bit rt, input bit rm, input logic [7:0] rc);
      bit walk, any, t, e_pv, e_tk, fin, e_done, e_ld;
      int fs;
      logic [31:0] spc, e_next;
      logic [3:0] rest;
      logic [7:0] lidx, ridx;
      logic [2:0] e_nv;
      string lreq;
      @(negedge clk);
      walk = m_active;
      any  = |m_rem;
      fs   = first_of(m_rem);
      spc  = m_addr + 32'(fs * 4);
      lidx = idx_of(spc, m_hist);
      t    = (m_ctr[lidx] >= 2);
      rest = m_rem & ~(4'b0001 << fs);
      e_pv = walk && any;
      e_tk = e_pv && t;
      fin  = !any || t || (rest == 4'b0);
      e_done = !walk || fin;
      e_ld   = walk && fin;
      e_next = e_tk ? m_tgt[fs] : m_addr + 32'd16;
      e_nv   = e_tk ? 3'(fs + 1) : 3'd4;

      chk(done_o == e_done, "R11", "done_o", 64'(done_o), 64'(e_done));
      chk(pred_valid_o == e_pv, prev_ignored ? "R10" : "R2", "pred_valid_o",
          64'(pred_valid_o), 64'(e_pv));
      if (e_pv) begin
         chk(pred_slot_o == 2'(fs), prev_ignored ? "R10" : "R2", "pred_slot_o",
             64'(pred_slot_o), 64'(fs));
         chk(pred_taken_o == t, "R6/R8", "pred_taken_o", 64'(pred_taken_o), 64'(t));
      end
      chk(pred_hist_o == m_hist, "R7/R9", "pred_hist_o", 64'(pred_hist_o), 64'(m_hist));
      chk(line_done_o == e_ld, "R3/R4", "line_done_o", 64'(line_done_o), 64'(e_ld));
      if (e_ld) begin
         lreq = e_tk ? "R3" : (any ? "R4" : "R5");
         chk(next_addr_o == e_next, lreq, "next_addr_o", 64'(next_addr_o), 64'(e_next));
         chk(nvalid_o == e_nv, lreq, "nvalid_o", 64'(nvalid_o), 64'(e_nv));
      end

      line_valid_i = lv; line_addr_i = la; line_brmask_i = lm; line_tgt_i = lt;
      resolve_valid_i = rv; resolve_pc_i = rpc; resolve_hist_i = rh;
      resolve_taken_i = rt; resolve_mispredict_i = rm; resolve_ckpt_i = rc;

      if (rv && rm) m_hist = rc;
      else if (e_pv) m_hist = {m_hist[6:0], t};
      if (rv) begin
         ridx = idx_of(rpc, rh);
         if (rt) begin
            if (m_ctr[ridx] < 3) m_ctr[ridx]++;
         end else if (m_ctr[ridx] > 0) m_ctr[ridx]--;
      end
      if (lv && e_done) begin
         m_active = 1'b1; m_addr = la; m_rem = lm;
         for (int s = 0; s < 4; s++) m_tgt[s] = lt[s*32 +: 32];
      end else if (e_ld) m_active = 1'b0;
      else if (e_pv) m_rem = rest;
      prev_ignored = lv && !e_done;
   endtask

   task automatic idle_step();
      step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
   endtask

   task automatic line_step(logic [31:0] la, logic [3:0] lm, logic [127:0] lt);
      step(1'b1, la, lm, lt, 1'b0, '0, '0, 1'b0, 1'b0, '0);
   endtask

   task automatic train_step(logic [31:0] pc, logic [7:0] h, bit tk);
      step(1'b0, '0, '0, '0, 1'b1, pc, h, tk, 1'b0, '0);
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : p_main
      logic [127:0] tg;
      int unsigned seed;
      seed = $urandom(32'h1B5E);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state at the ports
      chk(done_o == 1'b1, "R1", "done_o", 64'(done_o), 64'd1);
      chk(pred_valid_o == 1'b0, "R1", "pred_valid_o", 64'(pred_valid_o), 64'd0);
      chk(line_done_o == 1'b0, "R1", "line_done_o", 64'(line_done_o), 64'd0);
      chk(pred_hist_o == 8'h00, "R1", "pred_hist_o", 64'(pred_hist_o), 64'd0);

      tg = {32'h0000_4D00, 32'h0000_3C00, 32'h0000_2B00, 32'h0000_1A00};
      // R1/R4: fresh counters are weakly not taken, four steps through a full mask
      line_step(32'h0000_0100, 4'b1111, tg);
      repeat (3) idle_step();
      // R4: the final step is visible here
      idle_step();
      // R5: empty mask
      line_step(32'h0000_0200, 4'b0000, tg);
      idle_step();
      idle_step();
      // R8: push one counter past saturation and back by one
      repeat (5) train_step(32'h0000_0040, m_hist, 1'b1);
      train_step(32'h0000_0040, m_hist, 1'b0);
      // R3/R6: slot 0 now predicted taken
      line_step(32'h0000_0040, 4'b0001, tg);
      idle_step();
      // R10: offers during a walk are ignored
      line_step(32'h0000_0080, 4'b1111, tg);
      line_step(32'h0000_0300, 4'b0001, tg);
      // R9: mismatch in the same cycle as a prediction
      step(1'b1, 32'h0000_0300, 4'b0011, tg, 1'b1, 32'h0000_0124, 8'h11, 1'b1, 1'b1, 8'hA5);
      repeat (6) idle_step();

      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         bit lv, rv, rt, rm;
         logic [31:0] la, rpc;
         logic [3:0] lm;
         logic [7:0] rh, rc;
         lv = ($urandom_range(0, 9) < 7);
         la = {22'd0, 6'($urandom_range(0, 63)), 4'd0};
         lm = ($urandom_range(0, 9) == 0) ? 4'b0000 : 4'($urandom_range(0, 15));
         for (int s = 0; s < 4; s++) tg[s*32 +: 32] = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
         rv  = ($urandom_range(0, 9) < 4);
         rpc = m_active ? (m_addr + 32'(4 * $urandom_range(0, 3)))
                        : {22'd0, 8'($urandom_range(0, 255)), 2'b00};
         rh  = ($urandom_range(0, 1) == 1) ? m_hist : 8'($urandom_range(0, 255));
         rt  = ($urandom_range(0, 3) != 0);
         rm  = ($urandom_range(0, 19) < 3);
         rc  = 8'($urandom_range(0, 255));
         step(lv, la, lm, tg, rv, rpc, rh, rt, rm, rc);
      end
      repeat (6) idle_step();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule